// File: doc/BRIEF.md
# Memory-Mapped Keyboard and Display Port

This block is the interface circuit that sits between a simple processor bus and two character devices: a keyboard that hands over one character at a time and a display that accepts one character at a time. It takes a window of four consecutive addresses in the processor's ordinary memory map. A load or a store to one of those addresses reaches a register in the block, and the access is itself a command to a device. A load from the receive buffer consumes the keyboard character. A store to the transmit buffer hands a character to the display.

Software can poll the status register until a ready flag appears. It can also set enable bits in the control register and let the combined interrupt line tell it when a device needs service. A sticky overrun flag in the status register records that a keyboard character was lost because a newer one replaced it before software read it.

Register offsets within the window: 0 is the receive buffer, 1 is the transmit buffer, 2 is status and 3 is control. Status bit 0 is receive-ready, bit 1 is transmit-ready, bit 2 is overrun, bit 6 is the keyboard interrupt request and bit 7 is the display interrupt request. Control bit 0 is the keyboard interrupt enable and bit 1 is the display interrupt enable. Every other bit reads as zero.

Top module: `kbd_disp_port`

## Requirements
- R1: Only addresses BASE_ADDR to BASE_ADDR+3 select the block. An access outside that window leaves `bus_sel` low and `bus_rdata` at zero, and it changes no register, no flag and no device output.
- R2: A `kbd_valid` pulse stores `kbd_char` in the receive buffer and sets status bit 0. A read of offset 0 returns the stored character.
- R3: A read of offset 0 clears status bit 0 from the next cycle onward. If a new character arrives in the same cycle, bit 0 stays set and the new character is stored.
- R4: A write to offset 1 drives the written byte on `disp_char` from the next cycle onward, pulses `disp_load` for exactly that one cycle, and clears status bit 1.
- R5: Status bit 1 is set after reset and is set again by a `disp_done` pulse. If a write to offset 1 happens in the same cycle as `disp_done`, the write wins and bit 1 ends up clear.
- R6: Control bits 1:0 are written by a store to offset 3 and read back from it. Control bits 7:2 always read as zero.
- R7: Status bit 6 is (bit 0 AND control bit 0). Status bit 7 is (bit 1 AND control bit 1). `irq` is high exactly when bit 6 or bit 7 is set.
- R8: A character that arrives while bit 0 is set and no read of offset 0 happens in the same cycle overwrites the buffer and sets status bit 2. Bit 2 stays set until a read of offset 2 clears it, and a new overrun in the same cycle as that read wins.
- R9: Writes to offset 0 and offset 2 are ignored. They change neither the receive buffer nor any status bit.
- R10: After reset, status reads 0x02, control reads 0x00, and `irq` and `disp_load` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Processor address |
| bus_wdata | input | DATA_W | Processor write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read, zero otherwise |
| bus_sel | output | 1 | High when the address falls in the block's window |
| kbd_valid | input | 1 | Keyboard delivers a character this cycle |
| kbd_char | input | DATA_W | Keyboard character |
| disp_char | output | DATA_W | Character held for the display |
| disp_load | output | 1 | One-cycle pulse: a new character is on disp_char |
| disp_done | input | 1 | Display has consumed the last character |
| irq | output | 1 | Combined, enabled interrupt request |

## Verification
The assertions take for granted that `bus_rd` and `bus_wr` are never high in the same cycle and that `kbd_valid` and `disp_done` are single-cycle pulses sampled at the clock edge. The stimulus respects this: every bus access is a one-cycle strobe driven just after an edge and released after the next one, and device pulses are made the same way. The corner cases are placed deliberately. A keyboard character is made to arrive in the very cycle the receive buffer is read, and a display completion in the very cycle the transmit buffer is written, so that each priority rule is exercised.

// File: rtl/kdp_pkg.sv
// Package: shared register indices and status/control bit positions for the
// keyboard/display port. Assumes an 8-bit or wider data path.
package kdp_pkg;
    localparam int REG_IDX_W = 2;
    localparam int NUM_REGS  = 1 << REG_IDX_W;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_RXBUF = 2'd0,
        REG_TXBUF = 2'd1,
        REG_STAT  = 2'd2,
        REG_CTRL  = 2'd3
    } kdp_reg_e;

    localparam int ST_RX_RDY = 0;
    localparam int ST_TX_RDY = 1;
    localparam int ST_OVR    = 2;
    localparam int ST_RX_IRQ = 6;
    localparam int ST_TX_IRQ = 7;

    localparam int CT_RX_IE  = 0;
    localparam int CT_TX_IE  = 1;
    localparam int CT_BITS   = 2;
endpackage

// File: rtl/kdp_decode.sv
// Address decoder: compares the upper address bits with the window base and
// produces one read select and one write select per register.
// Assumes BASE_ADDR is aligned to the window size.
module kdp_decode
    import kdp_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFF00
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                rd,
    input  logic                wr,
    output logic                hit,
    output logic [NUM_REGS-1:0] rd_sel,
    output logic [NUM_REGS-1:0] wr_sel
);
    localparam int TAG_W = ADDR_W - REG_IDX_W;

    // Window hit: upper address bits match the base.
    assign hit = (addr[ADDR_W-1:REG_IDX_W] == BASE_ADDR[ADDR_W-1:REG_IDX_W]);

    // One select pair per register offset.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign rd_sel[i] = hit && rd && (addr[REG_IDX_W-1:0] == REG_IDX_W'(i));
        assign wr_sel[i] = hit && wr && (addr[REG_IDX_W-1:0] == REG_IDX_W'(i));
    end

    logic unused_tag_w;
    assign unused_tag_w = (TAG_W > 0);
endmodule

// File: rtl/kdp_rx_chan.sv
// Receive channel: holds the last keyboard character, its ready flag and the
// sticky overrun flag. Assumes kbd_valid is a one-cycle pulse per character.
module kdp_rx_chan #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kbd_valid,
    input  logic [DATA_W-1:0] kbd_char,
    input  logic              take,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] data,
    output logic              ready,
    output logic              overrun
);
    // Capture each delivered character.
    always_ff @(posedge clk) begin
        if (!rst_n)         data <= '0;
        else if (kbd_valid) data <= kbd_char;
    end

    // Ready flag: a new character sets it, a buffer read clears it; arrival wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         ready <= 1'b0;
        else if (kbd_valid) ready <= 1'b1;
        else if (take)      ready <= 1'b0;
    end

    // Sticky overrun: set on an unread overwrite, cleared by a status read; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                              overrun <= 1'b0;
        else if (kbd_valid && ready && !take)    overrun <= 1'b1;
        else if (ovr_clr)                        overrun <= 1'b0;
    end

    // R3
    rx_take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !kbd_valid) |=> !ready);

    // R8
    rx_overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_valid && ready && !take) |=> (overrun && data == $past(kbd_char)));

    // R8
    rx_overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);
endmodule

// File: rtl/kdp_tx_chan.sv
// Transmit channel: holds the character for the display, issues a one-cycle
// load pulse and tracks whether the display can take another character.
// Assumes disp_done is a one-cycle pulse.
module kdp_tx_chan #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic [DATA_W-1:0] wdata,
    input  logic              disp_done,
    output logic [DATA_W-1:0] disp_char,
    output logic              disp_load,
    output logic              ready
);
    // Hold the character most recently written for the display.
    always_ff @(posedge clk) begin
        if (!rst_n)        disp_char <= '0;
        else if (load_req) disp_char <= wdata;
    end

    // Load strobe follows a buffer write by one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) disp_load <= 1'b0;
        else        disp_load <= load_req;
    end

    // Ready flag: idle after reset, cleared by a write, set by completion; write wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         ready <= 1'b1;
        else if (load_req)  ready <= 1'b0;
        else if (disp_done) ready <= 1'b1;
    end

    // R4
    tx_load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> (disp_load && !ready && disp_char == $past(wdata)));

    // R5
    tx_done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_done && !load_req) |=> ready);
endmodule

// File: rtl/kbd_disp_port.sv
// Top: memory-mapped keyboard/display port. Decodes a four-register window,
// returns read data combinationally in the access cycle, applies side effects
// at the clock edge, and forms the enabled interrupt request.
// Assumes DATA_W >= 8, one-cycle strobes, and never rd and wr together.
module kbd_disp_port
    import kdp_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_sel,
    input  logic              kbd_valid,
    input  logic [DATA_W-1:0] kbd_char,
    output logic [DATA_W-1:0] disp_char,
    output logic              disp_load,
    input  logic              disp_done,
    output logic              irq
);
    logic [NUM_REGS-1:0] rd_sel;
    logic [NUM_REGS-1:0] wr_sel;
    logic [DATA_W-1:0]   rx_data;
    logic                rx_ready;
    logic                rx_ovr;
    logic                tx_ready;
    logic [CT_BITS-1:0]  ctrl_q;
    logic [DATA_W-1:0]   status_w;
    logic [DATA_W-1:0]   ctrl_w;
    logic                rx_irq;
    logic                tx_irq;

    kdp_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr   (bus_addr),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .hit    (bus_sel),
        .rd_sel (rd_sel),
        .wr_sel (wr_sel)
    );

    kdp_rx_chan #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .kbd_valid (kbd_valid),
        .kbd_char  (kbd_char),
        .take      (rd_sel[REG_RXBUF]),
        .ovr_clr   (rd_sel[REG_STAT]),
        .data      (rx_data),
        .ready     (rx_ready),
        .overrun   (rx_ovr)
    );

    kdp_tx_chan #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_req  (wr_sel[REG_TXBUF]),
        .wdata     (bus_wdata),
        .disp_done (disp_done),
        .disp_char (disp_char),
        .disp_load (disp_load),
        .ready     (tx_ready)
    );

    // Control register: interrupt enables, written only at its own offset.
    always_ff @(posedge clk) begin
        if (!rst_n)                ctrl_q <= '0;
        else if (wr_sel[REG_CTRL]) ctrl_q <= bus_wdata[CT_BITS-1:0];
    end

    // Gated per-device requests.
    always_comb begin
        rx_irq = rx_ready & ctrl_q[CT_RX_IE];
        tx_irq = tx_ready & ctrl_q[CT_TX_IE];
    end

    // Assemble status and control read images; unused bits are zero.
    always_comb begin
        status_w            = '0;
        status_w[ST_RX_RDY] = rx_ready;
        status_w[ST_TX_RDY] = tx_ready;
        status_w[ST_OVR]    = rx_ovr;
        status_w[ST_RX_IRQ] = rx_irq;
        status_w[ST_TX_IRQ] = tx_irq;
        ctrl_w              = '0;
        ctrl_w[CT_BITS-1:0] = ctrl_q;
    end

    // Read data mux: zero unless a read hits the window.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && bus_rd) begin
            case (kdp_reg_e'(bus_addr[REG_IDX_W-1:0]))
                REG_RXBUF: bus_rdata = rx_data;
                REG_TXBUF: bus_rdata = disp_char;
                REG_STAT:  bus_rdata = status_w;
                REG_CTRL:  bus_rdata = ctrl_w;
                default:   bus_rdata = '0;
            endcase
        end
    end

    // Combined interrupt output.
    assign irq = rx_irq | tx_irq;

    // R1
    outside_window_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_sel) |-> (bus_rdata == '0));

    // R6
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel[REG_CTRL] |=> $stable(ctrl_q));

    // R9
    rxbuf_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !kbd_valid) |=> $stable(rx_data));
endmodule

// File: tb/kbd_disp_port_tb.sv
// Scoreboard bench: read tasks push expected data into a queue, a negedge
// monitor pops and compares against bus_rdata; direct checks cover pins.
module kbd_disp_port_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          ADDR_W     = 16;
    localparam int          DATA_W     = 8;
    localparam logic [15:0] BASE       = 16'hFF00;

    typedef struct {
        logic [DATA_W-1:0] exp;
        string             tag;
    } exp_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_sel;
    logic              kbd_valid = 1'b0;
    logic [DATA_W-1:0] kbd_char = '0;
    logic [DATA_W-1:0] disp_char;
    logic              disp_load;
    logic              disp_done = 1'b0;
    logic              irq;

    int        n_checks = 0;
    int        n_errors = 0;
    exp_item_t sb_q[$];

    kbd_disp_port #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BASE_ADDR (BASE)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_rdata (bus_rdata),
        .bus_sel   (bus_sel),
        .kbd_valid (kbd_valid),
        .kbd_char  (kbd_char),
        .disp_char (disp_char),
        .disp_load (disp_load),
        .disp_done (disp_done),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                         input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // Monitor: compare read data mid-cycle against the scoreboard.
    always @(negedge clk) begin
        if (bus_rd) begin
            if (sb_q.size() == 0) begin
                n_checks++;
                n_errors++;
                $display("FAIL scoreboard empty: actual 0x%02h expected none", bus_rdata);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                check(bus_rdata, it.exp, it.tag);
            end
        end
    end

    task automatic rd_addr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                           input string tag);
        exp_item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(posedge clk); #1;
        bus_rd   = 1'b0;
    endtask

    task automatic rd_reg(input int off, input logic [DATA_W-1:0] exp, input string tag);
        rd_addr(BASE + ADDR_W'(off), exp, tag);
    endtask

    task automatic wr_addr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk); #1;
        bus_wr    = 1'b0;
    endtask

    task automatic kbd_push(input logic [DATA_W-1:0] c);
        kbd_char  = c;
        kbd_valid = 1'b1;
        @(posedge clk); #1;
        kbd_valid = 1'b0;
    endtask

    task automatic done_pulse();
        disp_done = 1'b1;
        @(posedge clk); #1;
        disp_done = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R10 reset state
        check(irq, 1'b0, "R10 irq");
        check(disp_load, 1'b0, "R10 disp_load");
        rd_reg(2, 8'h02, "R10 status");
        rd_reg(3, 8'h00, "R10 control");

        // R2 capture and ready
        kbd_push(8'h41);
        rd_reg(2, 8'h03, "R2 rx ready");
        rd_reg(0, 8'h41, "R2 rx char");
        rd_reg(2, 8'h02, "R3 ready cleared");

        // R8 overrun
        kbd_push(8'h10);
        kbd_push(8'h20);
        rd_reg(2, 8'h07, "R8 overrun set");
        rd_reg(2, 8'h03, "R8 overrun cleared");
        rd_reg(0, 8'h20, "R8 newest char kept");

        // R3 read and arrival in the same cycle
        kbd_push(8'h30);
        kbd_char  = 8'h31;
        kbd_valid = 1'b1;
        rd_reg(0, 8'h30, "R3 old char on collision");
        kbd_valid = 1'b0;
        rd_reg(2, 8'h03, "R3 ready kept, no overrun");
        rd_reg(0, 8'h31, "R3 new char stored");

        // R4 transmit write
        wr_addr(BASE + 16'd1, 8'h55);
        check(disp_load, 1'b1, "R4 load pulse");
        check(disp_char, 8'h55, "R4 disp_char");
        @(posedge clk); #1;
        check(disp_load, 1'b0, "R4 pulse one cycle");
        rd_reg(2, 8'h00, "R4 tx ready cleared");

        // R5 completion and collision
        done_pulse();
        rd_reg(2, 8'h02, "R5 tx ready set");
        disp_done = 1'b1;
        wr_addr(BASE + 16'd1, 8'h56);
        disp_done = 1'b0;
        rd_reg(2, 8'h00, "R5 write wins");
        done_pulse();

        // R6 control register
        wr_addr(BASE + 16'd3, 8'hFF);
        rd_reg(3, 8'h03, "R6 control readback");

        // R7 interrupt gating
        rd_reg(2, 8'h82, "R7 display request");
        check(irq, 1'b1, "R7 irq from display");
        wr_addr(BASE + 16'd3, 8'h01);
        rd_reg(2, 8'h02, "R7 display masked");
        check(irq, 1'b0, "R7 irq masked");
        kbd_push(8'h61);
        rd_reg(2, 8'h43, "R7 keyboard request");
        check(irq, 1'b1, "R7 irq from keyboard");
        rd_reg(0, 8'h61, "R7 drain");
        check(irq, 1'b0, "R7 irq drops after read");
        wr_addr(BASE + 16'd3, 8'h00);

        // R9 writes ignored
        wr_addr(BASE + 16'd2, 8'hFF);
        rd_reg(2, 8'h02, "R9 status write ignored");
        wr_addr(BASE + 16'd0, 8'h99);
        rd_reg(0, 8'h61, "R9 rx write ignored");
        rd_reg(2, 8'h02, "R9 status unchanged");

        // R1 outside the window
        wr_addr(BASE + 16'd4, 8'h77);
        check(disp_load, 1'b0, "R1 no load outside");
        check(disp_char, 8'h56, "R1 disp_char unchanged");
        rd_reg(3, 8'h00, "R1 control unchanged");
        bus_addr = BASE - 16'd1;
        #1 check(bus_sel, 1'b0, "R1 sel low below base");
        rd_addr(BASE - 16'd1, 8'h00, "R1 read below base");
        kbd_push(8'h7A);
        rd_addr(BASE + 16'd4, 8'h00, "R1 read above window");
        rd_reg(2, 8'h03, "R1 no side effect");

        @(posedge clk); #1;
        if (sb_q.size() != 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL scoreboard leftover: actual %0d expected 0", sb_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule